// File: doc/BRIEF.md
# Edge-Triggered Waveform Capture Controller

This block sits between a single-channel 8-bit sample stream and a DMA engine. Once armed, it stores every incoming sample in a circular history buffer. It watches the live stream for an edge that crosses a programmable level with programmable hysteresis. When the trigger fires, it keeps recording a programmed number of samples that begin with the trigger sample. It then replays the whole record as one stream packet. The packet holds the programmed number of samples from before the trigger, followed by the samples from the trigger onward, oldest first, with the last beat marked.

The trigger can be set for rising, falling or either edges. A force input fires the trigger without an edge. Triggers are held off until the pre-trigger part of the buffer holds enough samples, so every packet carries a full history window. Software sets the threshold, hysteresis, edge mode and both record lengths through static configuration inputs. It then starts a capture with a one-cycle arm pulse. In continuous mode the block re-arms itself as soon as a packet has been accepted, which produces one packet per trigger.

Top module: `scope_capture`

## Requirements
- R1: After reset the block is idle: busy is low, the stream outputs are idle (valid and last low), the reported trigger index is 0 and the buffer write position is 0.
- R2: A one-cycle arm pulse while idle starts a capture and latches the pre and post lengths. Busy is high from the next cycle until the last beat is accepted. Arm pulses while busy are ignored and do not restart the history count.
- R3: While capturing, each valid sample is written at the current write position. That position advances by one per stored sample, modulo DEPTH, and is not reset by arming. Samples that arrive while idle or during readout are dropped.
- R4: Edge mode 0 (rising) fires on a stored sample at or above the level when the previous sample stored since arming plus the hysteresis is below the level. The first sample after arming cannot fire an edge.
- R5: Edge mode 1 (falling) fires on a sample at or below the level when the previous sample stored since arming is above the level plus the hysteresis. The sums are taken without wraparound.
- R6: Edge modes 2 and 3 fire on either a rising or a falling edge, as defined in R4 and R5.
- R7: No trigger, whether from an edge or forced, is accepted on a sample until at least pre-length samples have been stored since arming.
- R8: With the force input high, the next stored sample that is eligible under R7 becomes the trigger sample, whatever the edge condition.
- R9: The trigger sample is the first of the post-length samples, and recording stops after the post-length-th sample. The post length must be at least 1, and pre plus post must not exceed DEPTH.
- R10: Readout emits pre+post beats, oldest first. The first beat is the sample stored pre positions before the trigger sample. Last is high on the final beat only, and valid and data hold while ready is low.
- R11: The trigger index output gives the write position of the trigger sample. It is valid from the start of readout and holds until the next trigger.
- R12: If continuous mode is high when the last beat is accepted, the block re-arms at once, re-latching the lengths, and busy stays high. Otherwise it returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_data | input | SW (8) | Incoming ADC sample |
| smp_valid | input | 1 | Sample qualifier |
| cfg_level | input | SW (8) | Trigger threshold |
| cfg_hyst | input | SW (8) | Trigger hysteresis |
| cfg_mode | input | 2 | Edge mode: 0 rising, 1 falling, 2/3 either |
| cfg_pre | input | LW (7) | Samples kept before the trigger |
| cfg_post | input | LW (7) | Samples recorded from the trigger on |
| cfg_continuous | input | 1 | Re-arm automatically after each packet |
| ctl_arm | input | 1 | Start a capture (pulse) |
| ctl_force | input | 1 | Force the trigger once the window is full |
| m_tdata | output | SW (8) | Packet data |
| m_tvalid | output | 1 | Packet beat valid |
| m_tready | input | 1 | Downstream ready |
| m_tlast | output | 1 | Final beat of the packet |
| sts_busy | output | 1 | Capture or readout in progress |
| sts_trig_idx | output | AW (6) | Buffer position of the trigger sample |

## Verification
The assertions check on every cycle that the write position steps by one per stored sample and that no trigger is taken before the history count reaches the pre length. They also check that valid and the read address hold under back-pressure, that last only appears with valid, that the trigger index is steady during readout, and that a rising-edge hit really crosses the level. Whether the packet holds the right samples, in the right order, around the right trigger (given hysteresis, edge mode, force, ignored arm pulses and continuous re-arming) can only be shown by the bench. The bench compares each packet with a record it builds from its own copy of the stream.

// File: rtl/scap_pkg.sv
// Shared types for the capture controller.
// Assumes: nothing beyond the IEEE 1800-2017 language.
package scap_pkg;

    // Controller phases, in the order a capture moves through them.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMING,
        ST_WAIT,
        ST_POST,
        ST_READ
    } cap_state_t;

    // Edge mode codes; any other code means either edge.
    localparam logic [1:0] MODE_RISE = 2'b00;
    localparam logic [1:0] MODE_FALL = 2'b01;

endpackage

// File: rtl/scap_edge_det.sv
// Edge detector on the live sample stream, with hysteresis.
// Keeps the previous stored sample since the last restart and flags, combinationally,
// whether the current sample completes a rising and/or falling edge.
// Assumes: restart and smp_store are never high together.
module scap_edge_det
    import scap_pkg::*;
#(
    parameter int SW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          smp_store,
    input  logic [SW-1:0] smp_data,
    input  logic [SW-1:0] level,
    input  logic [SW-1:0] hyst,
    input  logic [1:0]    mode,
    output logic          hit
);

    logic [SW-1:0] prev_q;
    logic          prev_ok_q;
    logic [SW:0]   low_sum;
    logic [SW:0]   high_sum;
    logic          rise;
    logic          fall;

    // Hold the last stored sample; forget it when a new capture starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q    <= '0;
            prev_ok_q <= 1'b0;
        end else if (restart) begin
            prev_ok_q <= 1'b0;
        end else if (smp_store) begin
            prev_q    <= smp_data;
            prev_ok_q <= 1'b1;
        end
    end

    // Edge conditions with overflow-free sums.
    always_comb begin
        low_sum  = {1'b0, prev_q} + {1'b0, hyst};
        high_sum = {1'b0, level} + {1'b0, hyst};
        rise     = prev_ok_q && (low_sum < {1'b0, level}) && (smp_data >= level);
        fall     = prev_ok_q && ({1'b0, prev_q} > high_sum) && (smp_data <= level);
        case (mode)
            MODE_RISE: hit = rise;
            MODE_FALL: hit = fall;
            default:   hit = rise || fall;
        endcase
    end

    // R4: a rising hit needs the previous sample below and the current at/above the level.
    a_r4_rise_crosses: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && mode == MODE_RISE) |-> (prev_q < level && smp_data >= level));

    // R4: no edge can fire on the first sample after a restart.
    a_r4_first_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !hit);

endmodule

// File: rtl/scap_ring.sv
// Circular sample store with one write port and one asynchronous read port.
// The write position is free-running across captures and wraps at DEPTH.
// Assumes: rd_addr < DEPTH.
module scap_ring #(
    parameter int SW    = 8,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [SW-1:0] wdata,
    input  logic [AW-1:0] rd_addr,
    output logic [SW-1:0] rdata,
    output logic [AW-1:0] wptr
);

    logic [SW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr_nxt;

    // Next write position; power-of-two depths wrap for free.
    generate
        if (DEPTH == (1 << AW)) begin : g_pow2
            assign wptr_nxt = wptr + 1'b1;
        end else begin : g_mod
            assign wptr_nxt = (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
        end
    endgenerate

    // Sample storage; contents need no reset.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[wptr] <= wdata;
        end
    end

    // Write position advances once per stored sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
        end else if (we) begin
            wptr <= wptr_nxt;
        end
    end

    assign rdata = mem[rd_addr];

    // R3: every store moves the write position exactly one place, modulo DEPTH.
    a_r3_wptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> wptr == (($past(wptr) == AW'(DEPTH - 1)) ? '0 : $past(wptr) + 1'b1));

    // R3: without a store the position holds.
    a_r3_wptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(wptr));

endmodule

// File: rtl/scap_seq.sv
// Capture sequencer: arm, fill the history window, wait for the trigger,
// record the post-trigger samples, then replay the record as one stream packet.
// Assumes: cfg_post >= 1 and cfg_pre + cfg_post <= DEPTH at each arm or re-arm.
module scap_seq
    import scap_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_valid,
    input  logic          hit,
    input  logic          ctl_arm,
    input  logic          ctl_force,
    input  logic [LW-1:0] cfg_pre,
    input  logic [LW-1:0] cfg_post,
    input  logic          cfg_continuous,
    input  logic [AW-1:0] wptr,
    input  logic          m_tready,
    output logic          store,
    output logic          restart,
    output logic [AW-1:0] rd_addr,
    output logic          m_tvalid,
    output logic          m_tlast,
    output logic          busy,
    output logic [AW-1:0] trig_idx
);

    cap_state_t    state;
    logic [LW-1:0] pre_q;
    logic [LW-1:0] post_q;
    logic [LW-1:0] fill_q;
    logic [LW-1:0] post_rem;
    logic [LW-1:0] out_left;
    logic [AW-1:0] rd_ptr;
    logic          capturing;
    logic          fire;
    logic          beat;
    logic          last_beat;

    // Position b places behind a, modulo DEPTH (b <= DEPTH).
    function automatic logic [AW-1:0] back_mod(input logic [AW-1:0] a, input logic [LW-1:0] b);
        logic [AW+1:0] t;
        t = (AW+2)'(a) + (AW+2)'(DEPTH) - (AW+2)'(b);
        if (t >= (AW+2)'(DEPTH)) begin
            t = t - (AW+2)'(DEPTH);
        end
        return t[AW-1:0];
    endfunction

    // Position one place ahead, modulo DEPTH.
    function automatic logic [AW-1:0] fwd_mod(input logic [AW-1:0] a);
        return (a == AW'(DEPTH - 1)) ? '0 : a + 1'b1;
    endfunction

    // Per-cycle strobes derived from the phase and the handshakes.
    always_comb begin
        capturing = (state == ST_ARMING) || (state == ST_WAIT) || (state == ST_POST);
        store     = capturing && smp_valid;
        fire      = (state == ST_WAIT) && smp_valid && (hit || ctl_force);
        beat      = (state == ST_READ) && m_tready;
        last_beat = beat && (out_left == LW'(1));
        restart   = ((state == ST_IDLE) && ctl_arm) || (last_beat && cfg_continuous);
    end

    // Phase register and the counters that drive it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            pre_q    <= '0;
            post_q   <= '0;
            fill_q   <= '0;
            post_rem <= '0;
            out_left <= '0;
            rd_ptr   <= '0;
            trig_idx <= '0;
        end else if (restart) begin
            pre_q  <= cfg_pre;
            post_q <= cfg_post;
            fill_q <= '0;
            state  <= (cfg_pre == '0) ? ST_WAIT : ST_ARMING;
        end else begin
            case (state)
                ST_ARMING: begin
                    if (smp_valid) begin
                        fill_q <= fill_q + LW'(1);
                        if (fill_q + LW'(1) == pre_q) begin
                            state <= ST_WAIT;
                        end
                    end
                end
                ST_WAIT: begin
                    if (fire) begin
                        trig_idx <= wptr;
                        rd_ptr   <= back_mod(wptr, pre_q);
                        post_rem <= post_q - LW'(1);
                        out_left <= pre_q + post_q;
                        state    <= (post_q == LW'(1)) ? ST_READ : ST_POST;
                    end
                end
                ST_POST: begin
                    if (smp_valid) begin
                        post_rem <= post_rem - LW'(1);
                        if (post_rem == LW'(1)) begin
                            state <= ST_READ;
                        end
                    end
                end
                ST_READ: begin
                    if (beat) begin
                        rd_ptr   <= fwd_mod(rd_ptr);
                        out_left <= out_left - LW'(1);
                        if (last_beat) begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign rd_addr  = rd_ptr;
    assign m_tvalid = (state == ST_READ);
    assign m_tlast  = m_tvalid && (out_left == LW'(1));
    assign busy     = (state != ST_IDLE);

    // R7: a trigger is only taken once the history count has reached the pre length.
    a_r7_window_full: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> fill_q == pre_q);

    // R9: the post length must not be zero when a capture starts.
    a_r9_post_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        restart |-> cfg_post != '0);

    // R10: under back-pressure the beat and its address are held.
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !m_tready) |=> (m_tvalid && $stable(rd_addr)));

    // R10: last only marks a valid beat.
    a_r10_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
        m_tlast |-> m_tvalid);

    // R2: when not busy, nothing is stored and nothing is offered.
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!m_tvalid && !store));

    // R11: the trigger index holds throughout readout.
    a_r11_idx_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READ && $past(state) == ST_READ) |-> $stable(trig_idx));

endmodule

// File: rtl/scope_capture.sv
// Top of the pre/post trigger capture controller: ties the edge detector,
// the circular store and the sequencer together.
// Assumes: configuration inputs are stable while busy, except cfg_continuous,
// which is read when the last beat is accepted.
module scope_capture #(
    parameter int SW    = 8,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] smp_data,
    input  logic          smp_valid,
    input  logic [SW-1:0] cfg_level,
    input  logic [SW-1:0] cfg_hyst,
    input  logic [1:0]    cfg_mode,
    input  logic [LW-1:0] cfg_pre,
    input  logic [LW-1:0] cfg_post,
    input  logic          cfg_continuous,
    input  logic          ctl_arm,
    input  logic          ctl_force,
    output logic [SW-1:0] m_tdata,
    output logic          m_tvalid,
    input  logic          m_tready,
    output logic          m_tlast,
    output logic          sts_busy,
    output logic [AW-1:0] sts_trig_idx
);

    logic          store;
    logic          restart;
    logic          hit;
    logic [AW-1:0] wptr;
    logic [AW-1:0] rd_addr;

    scap_edge_det #(.SW(SW)) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .smp_store (store),
        .smp_data  (smp_data),
        .level     (cfg_level),
        .hyst      (cfg_hyst),
        .mode      (cfg_mode),
        .hit       (hit)
    );

    scap_ring #(.SW(SW), .DEPTH(DEPTH)) u_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (store),
        .wdata   (smp_data),
        .rd_addr (rd_addr),
        .rdata   (m_tdata),
        .wptr    (wptr)
    );

    scap_seq #(.DEPTH(DEPTH)) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .smp_valid      (smp_valid),
        .hit            (hit),
        .ctl_arm        (ctl_arm),
        .ctl_force      (ctl_force),
        .cfg_pre        (cfg_pre),
        .cfg_post       (cfg_post),
        .cfg_continuous (cfg_continuous),
        .wptr           (wptr),
        .m_tready       (m_tready),
        .store          (store),
        .restart        (restart),
        .rd_addr        (rd_addr),
        .m_tvalid       (m_tvalid),
        .m_tlast        (m_tlast),
        .busy           (sts_busy),
        .trig_idx       (sts_trig_idx)
    );

endmodule

// File: tb/scope_capture_tb_top.sv
// Self-checking bench: builds each expected packet from its own copy of the stream.
module scope_capture_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int SW    = 8;
    localparam int DEPTH = 64;
    localparam int AW    = $clog2(DEPTH);
    localparam int LW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [SW-1:0] smp_data = '0;
    logic          smp_valid = 1'b0;
    logic [SW-1:0] cfg_level = '0;
    logic [SW-1:0] cfg_hyst = '0;
    logic [1:0]    cfg_mode = '0;
    logic [LW-1:0] cfg_pre = '0;
    logic [LW-1:0] cfg_post = LW'(1);
    logic          cfg_continuous = 1'b0;
    logic          ctl_arm = 1'b0;
    logic          ctl_force = 1'b0;
    logic [SW-1:0] m_tdata;
    logic          m_tvalid;
    logic          m_tready = 1'b0;
    logic          m_tlast;
    logic          sts_busy;
    logic [AW-1:0] sts_trig_idx;

    int n_checks = 0;
    int n_fail   = 0;
    int wtotal   = 0;
    logic [SW-1:0] hist[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    scope_capture #(.SW(SW), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .smp_data(smp_data), .smp_valid(smp_valid),
        .cfg_level(cfg_level), .cfg_hyst(cfg_hyst), .cfg_mode(cfg_mode),
        .cfg_pre(cfg_pre), .cfg_post(cfg_post), .cfg_continuous(cfg_continuous),
        .ctl_arm(ctl_arm), .ctl_force(ctl_force), .m_tdata(m_tdata),
        .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tlast(m_tlast),
        .sts_busy(sts_busy), .sts_trig_idx(sts_trig_idx)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Edge rule from R4, R5 and R6.
    function automatic bit edge_fn(input int prev, input int cur, input int lvl,
                                   input int hy, input int mode);
        bit rise, fall;
        rise = (prev + hy < lvl) && (cur >= lvl);
        fall = (prev > lvl + hy) && (cur <= lvl);
        if (mode == 0) return rise;
        if (mode == 1) return fall;
        return rise || fall;
    endfunction

    // Stimulus waveforms: noise, ramp, square, triangle.
    function automatic logic [SW-1:0] gen(input int pattern, input int n);
        case (pattern)
            0:       return SW'($urandom);
            1:       return SW'(n * 7);
            2:       return ((n / 5) % 2 == 0) ? 8'h20 : 8'hE0;
            default: return ((n % 64) < 32) ? SW'((n % 32) * 8) : SW'(255 - (n % 32) * 8);
        endcase
    endfunction

    // One capture: optional arm, stream samples, then drain and compare the packet.
    task automatic capture(input int pre, input int post, input int lvl, input int hy,
                           input int mode, input int pattern, input int force_at,
                           input bit do_arm, input bit cont, input bit arm_noise);
        int trig_pos = -1;
        int exp_idx  = 0;
        int n = 0;
        int len;
        int k = 0;
        cfg_pre = LW'(pre); cfg_post = LW'(post); cfg_level = SW'(lvl);
        cfg_hyst = SW'(hy); cfg_mode = 2'(mode); cfg_continuous = cont;
        hist.delete();
        if (do_arm) begin
            ctl_arm = 1'b1;
            @(negedge clk);
            ctl_arm = 1'b0;
        end
        chk(sts_busy == 1'b1, "R2 busy after arm", int'(sts_busy), 1);
        while (1) begin
            bit v;
            logic [SW-1:0] d;
            v = ($urandom % 4) != 0;
            d = gen(pattern, n);
            smp_valid = v;
            smp_data  = d;
            ctl_force = (n >= force_at);
            ctl_arm   = arm_noise;
            if (v) begin
                if (trig_pos < 0 && hist.size() >= pre &&
                    (ctl_force || (hist.size() > 0 && edge_fn(int'(hist[$]), int'(d), lvl, hy, mode)))) begin
                    trig_pos = hist.size();
                    exp_idx  = wtotal % DEPTH;
                end
                hist.push_back(d);
                wtotal++;
            end
            n++;
            @(negedge clk);
            if (trig_pos >= 0 && hist.size() == trig_pos + post) break;
        end
        smp_valid = 1'b0; ctl_force = 1'b0; ctl_arm = 1'b0;
        chk(m_tvalid == 1'b1, "R9 readout starts after last post sample", int'(m_tvalid), 1);
        chk(int'(sts_trig_idx) == exp_idx, "R11 trigger index", int'(sts_trig_idx), exp_idx);
        len = pre + post;
        while (k < len) begin
            m_tready = ($urandom % 3) != 0;
            #1;
            if (m_tready) begin
                chk(m_tdata == hist[trig_pos - pre + k], "R10 packet data",
                    int'(m_tdata), int'(hist[trig_pos - pre + k]));
                chk(m_tlast == (k == len - 1), "R10 last marker", int'(m_tlast), int'(k == len - 1));
                k++;
            end else begin
                chk(m_tvalid == 1'b1, "R10 valid held", int'(m_tvalid), 1);
            end
            @(negedge clk);
        end
        m_tready = 1'b0;
        chk(sts_busy == cont, "R12 busy after last beat", int'(sts_busy), int'(cont));
        chk(m_tvalid == 1'b0, "R10 no beat after last", int'(m_tvalid), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(sts_busy == 1'b0, "R1 busy in reset", int'(sts_busy), 0);
        chk(m_tvalid == 1'b0, "R1 valid in reset", int'(m_tvalid), 0);
        chk(m_tlast == 1'b0, "R1 last in reset", int'(m_tlast), 0);
        chk(sts_trig_idx == '0, "R1 trig index in reset", int'(sts_trig_idx), 0);
        rst_n = 1'b1;
        // R3: samples while idle are dropped (model does not count them).
        smp_valid = 1'b1; smp_data = 8'hFF;
        repeat (4) @(negedge clk);
        smp_valid = 1'b0;
        chk(sts_busy == 1'b0, "R3 idle stays idle", int'(sts_busy), 0);
        // R4 rising on a ramp; also proves write position started at 0 (R1).
        capture(8, 8, 100, 4, 0, 1, 1000, 1, 0, 0);
        // R5 falling on a triangle.
        capture(12, 20, 90, 10, 1, 3, 1000, 1, 0, 0);
        // R6 either edge on a square wave.
        capture(5, 5, 128, 16, 2, 2, 1000, 1, 0, 0);
        // R7 with a square wave whose edges come before the window is full; R2 arm held high.
        capture(30, 4, 128, 16, 3, 2, 1000, 1, 0, 1);
        // R8 hysteresis too wide for the square: only the force fires.
        capture(10, 10, 128, 112, 0, 2, 40, 1, 0, 0);
        // R9 boundaries: full-depth history, then full-depth post.
        capture(DEPTH - 1, 1, 128, 0, 2, 0, 200, 1, 0, 0);
        capture(0, DEPTH, 128, 0, 0, 0, 200, 1, 0, 0);
        capture(0, 1, 0, 0, 2, 0, 0, 1, 0, 0);
        // R12 continuous: second capture needs no arm pulse.
        capture(16, 16, 100, 8, 0, 1, 1000, 1, 1, 0);
        capture(16, 16, 100, 8, 0, 1, 1000, 0, 0, 0);
        // Random configurations.
        for (int i = 0; i < 25; i++) begin
            int pre, post;
            pre  = $urandom % DEPTH;
            post = 1 + ($urandom % (DEPTH - pre));
            capture(pre, post, $urandom % 256, $urandom % 40, $urandom % 4,
                    $urandom % 4, 100 + ($urandom % 200), 1, 0, ($urandom % 2) == 1);
        end
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule